// File: doc/BRIEF.md
# Clock Gate Controller with Software/Hardware Ownership

This block owns the enable of one gated clock. A small control register decides who drives the gate. When the register selects software ownership, a software enable bit turns the clock on or off. When it selects hardware ownership, an external request line does so, and the software enable bit has no effect. The block does not produce the clock. It drives a registered gate-enable output that a clock-gating cell downstream consumes.

Changes to the gate do not take effect at once. A turn-on lands a fixed number of cycles after the new request is seen. A turn-off can be stretched by an optional hysteresis, which has a short and a long setting. A read-only status bit follows the real gate, so software polls it after a change until it matches the requested state. If the request comes back while a turn-off is still pending, the turn-off is dropped and the gate stays on without a gap. The register can be written only while a separate unlock input is high. A build parameter marks a gate that must never be switched off by software. For such a gate, software ownership keeps the clock running whatever the enable bit holds.

Top module: `clkgate_ctrl`

## Requirements
- R1: After reset the control register reads 5'b00001: bit0 (owner select) is 1, meaning software ownership. Bits 1 to 3 are 0. Bit4 (status) is 0, and gate_en_o is 0.
- R2: A write on wr_en_i changes the register only when unlock_i is high in the same cycle. A write made without unlock leaves the register and gate_en_o unchanged. Write data bits: bit0 is the owner select, bit1 the software enable, bit2 the hysteresis enable and bit3 the long-delay select.
- R3: In software ownership, setting the enable bit raises gate_en_o exactly ON_DLY (default 2) clock edges after the edge that captures the write.
- R4: With hysteresis disabled, a turn-off lowers gate_en_o exactly OFF_DLY (default 2) edges after the request is removed.
- R5: With hysteresis enabled and the long-delay select at 0, a turn-off takes HYST_LO (default 8) edges.
- R6: With hysteresis enabled and the long-delay select at 1, a turn-off takes HYST_HI (default 32) edges.
- R7: With the owner select at 0, the hardware request hw_req_i controls the gate and the software enable bit is ignored. hw_req_i is registered once, and the turn-on and turn-off delays then apply from the edge that samples it.
- R8: If the request returns while a turn-off delay is still running, the turn-off is cancelled and gate_en_o stays high in every cycle.
- R9: When NO_DISABLE is set, software ownership keeps the gate on even when the enable bit is 0.
- R10: Read bit4 of rd_data_o always equals gate_en_o. Bits 3 to 0 read back the stored control fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| unlock_i | input | 1 | Write unlock; writes are accepted only while high |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 4 | Write data for the control fields |
| hw_req_i | input | 1 | Hardware clock request, used under hardware ownership |
| rd_data_o | output | 5 | Status bit and control fields |
| gate_en_o | output | 1 | Registered gate enable for the clock-gating cell |

## Verification
The hardest case to reach is a re-enable that arrives in the middle of a long turn-off hysteresis. The bench sets up the long delay, removes the enable, waits ten cycles into the 32-cycle window, and then writes the enable back. Before it does so, it queues an expected "on" value for every one of the following forty cycles, so a single-cycle drop of the gate is caught. A second instance built with NO_DISABLE shares the same bus. It shows the gate held on under software ownership and the same delay behaviour under hardware ownership.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
  localparam int CTRL_W = 4;
  localparam int RD_W   = CTRL_W + 1;
  localparam int F_STAT = CTRL_W;

  typedef struct packed {
    logic hyst_long;
    logic hyst_en;
    logic sw_en;
    logic sw_sel;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{hyst_long: 1'b0, hyst_en: 1'b0, sw_en: 1'b0, sw_sel: 1'b1};
endpackage

// File: rtl/clkgate_regs.sv
module clkgate_regs
  import clkgate_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              unlock_i,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  input  logic              status_i,
  output ctrl_t             ctrl_o,
  output logic [RD_W-1:0]   rd_data_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RESET;
    end else if (wr_en_i && unlock_i) begin
      ctrl_q <= ctrl_t'(wr_data_i);
    end
  end

  assign ctrl_o    = ctrl_q;
  assign rd_data_o = {status_i, ctrl_q};

  AST_LOCKED_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    !unlock_i |=> $stable(ctrl_q)); // R2
  AST_UNLOCKED_WRITE: assert property (@(posedge clk) disable iff (rst)
    (unlock_i && wr_en_i) |=> (ctrl_q == $past(wr_data_i))); // R2
endmodule

// File: rtl/clkgate_timer.sv
module clkgate_timer #(
  parameter int ON_DLY  = 2,
  parameter int OFF_DLY = 2,
  parameter int HYST_LO = 8,
  parameter int HYST_HI = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic hyst_en_i,
  input  logic hyst_long_i,
  output logic gate_o
);
  localparam int MAX_A = (ON_DLY > OFF_DLY) ? ON_DLY : OFF_DLY;
  localparam int MAX_B = (HYST_LO > HYST_HI) ? HYST_LO : HYST_HI;
  localparam int MAX_D = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_D + 1);

  logic             gate_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_m1;

  always_comb begin
    if (!gate_q)          lim_m1 = CNT_W'(ON_DLY - 1);
    else if (!hyst_en_i)  lim_m1 = CNT_W'(OFF_DLY - 1);
    else if (hyst_long_i) lim_m1 = CNT_W'(HYST_HI - 1);
    else                  lim_m1 = CNT_W'(HYST_LO - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= 1'b0;
      cnt_q  <= '0;
    end else if (req_i == gate_q) begin
      cnt_q  <= '0;
    end else if (cnt_q >= lim_m1) begin
      gate_q <= ~gate_q;
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign gate_o = gate_q;

  AST_RISE_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_q) |-> $past(req_i)); // R3
  AST_FALL_NEEDS_DROP: assert property (@(posedge clk) disable iff (rst)
    $fell(gate_q) |-> !$past(req_i)); // R4
  AST_HELD_ON: assert property (@(posedge clk) disable iff (rst)
    (gate_q && req_i) |=> gate_q); // R8
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CNT_W'(MAX_D)); // R6
endmodule

// File: rtl/clkgate_ctrl.sv
module clkgate_ctrl
  import clkgate_pkg::*;
#(
  parameter int ON_DLY     = 2,
  parameter int OFF_DLY    = 2,
  parameter int HYST_LO    = 8,
  parameter int HYST_HI    = 32,
  parameter bit NO_DISABLE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              unlock_i,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  input  logic              hw_req_i,
  output logic [RD_W-1:0]   rd_data_o,
  output logic              gate_en_o
);
  ctrl_t ctrl;
  logic  hw_q;
  logic  req;
  logic  gate;

  always_ff @(posedge clk) begin
    if (rst) hw_q <= 1'b0;
    else     hw_q <= hw_req_i;
  end

  assign req = ctrl.sw_sel ? (ctrl.sw_en | NO_DISABLE) : hw_q;

  clkgate_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .unlock_i  (unlock_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .status_i  (gate),
    .ctrl_o    (ctrl),
    .rd_data_o (rd_data_o)
  );

  clkgate_timer #(
    .ON_DLY  (ON_DLY),
    .OFF_DLY (OFF_DLY),
    .HYST_LO (HYST_LO),
    .HYST_HI (HYST_HI)
  ) u_timer (
    .clk         (clk),
    .rst         (rst),
    .req_i       (req),
    .hyst_en_i   (ctrl.hyst_en),
    .hyst_long_i (ctrl.hyst_long),
    .gate_o      (gate)
  );

  assign gate_en_o = gate;

  AST_NO_DISABLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (NO_DISABLE && ctrl.sw_sel && gate) |=> gate); // R9
  AST_HW_IGNORES_EN: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.sw_sel && !hw_q && !gate) |=> !gate); // R7
endmodule

// File: tb/clkgate_ctrl_bench.sv
module clkgate_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       unlock = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_data = '0;
  logic       hw_req = 1'b0;
  logic [4:0] rd_m, rd_nd;
  logic       gate_m, gate_nd;
  int         cyc = 0;
  int         checks = 0;
  int         fails = 0;
  bit         done = 0;
  logic       g_s;
  logic [4:0] r_s;

  typedef struct {
    int         cyc;
    bit         nd;
    logic       g;
    bit         chkrd;
    logic [4:0] rd;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  clkgate_ctrl u_clkgate_ctrl (
    .clk(clk), .rst(rst), .unlock_i(unlock), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .hw_req_i(hw_req), .rd_data_o(rd_m), .gate_en_o(gate_m));

  clkgate_ctrl #(.NO_DISABLE(1'b1)) u_nd (
    .clk(clk), .rst(rst), .unlock_i(unlock), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .hw_req_i(hw_req), .rd_data_o(rd_nd), .gate_en_o(gate_nd));

  task automatic push(input int c, input bit nd, input logic g, input bit chkrd,
                      input logic [4:0] rd, input string tag);
    exp_t e;
    e.cyc = c; e.nd = nd; e.g = g; e.chkrd = chkrd; e.rd = rd; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic edge_at(input bit nd, input int t0, input int d, input logic v, input string tag);
    push(t0 + d - 1, nd, ~v, 0, '0, tag);
    push(t0 + d, nd, v, 0, '0, tag);
  endtask

  task automatic do_write(input logic [3:0] d, input logic unl);
    wr_en = 1'b1; wr_data = d; unlock = unl;
    @(negedge clk);
    wr_en = 1'b0; unlock = 1'b0;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      for (int i = sb.size() - 1; i >= 0; i--) begin
        if (sb[i].cyc == cyc) begin
          g_s = sb[i].nd ? gate_nd : gate_m;
          r_s = sb[i].nd ? rd_nd : rd_m;
          checks++;
          if (g_s !== sb[i].g || (sb[i].chkrd && r_s !== sb[i].rd)) begin
            fails++;
            $display("FAIL %s cyc=%0d nd=%0d gate=%b exp=%b rd=%b exp=%b",
                     sb[i].tag, cyc, sb[i].nd, g_s, sb[i].g, r_s, sb[i].rd);
          end
          sb.delete(i);
        end
      end
    end
  end

  initial begin
    int n;
    int t0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    n = cyc;
    push(n + 1, 0, 0, 1, 5'b00001, "R1");
    push(n + 1, 1, 0, 1, 5'b00001, "R9");
    push(n + 2, 1, 1, 1, 5'b10001, "R9");
    idle(3);
    // R2: locked write has no effect
    n = cyc;
    push(n + 4, 0, 0, 1, 5'b00001, "R2");
    do_write(4'b0011, 1'b0);
    idle(5);
    // R3: software turn-on
    n = cyc;
    edge_at(0, n + 1, 2, 1, "R3");
    push(n + 3, 0, 1, 1, 5'b10011, "R10");
    do_write(4'b0011, 1'b1);
    idle(4);
    // R4: plain turn-off; R9 no-disable instance stays on
    n = cyc;
    edge_at(0, n + 1, 2, 0, "R4");
    push(n + 4, 0, 0, 1, 5'b00001, "R10");
    push(n + 5, 1, 1, 1, 5'b10001, "R9");
    do_write(4'b0001, 1'b1);
    idle(5);
    // R5: short hysteresis
    n = cyc;
    edge_at(0, n + 1, 2, 1, "R3");
    do_write(4'b0111, 1'b1);
    idle(4);
    n = cyc;
    edge_at(0, n + 1, 8, 0, "R5");
    do_write(4'b0101, 1'b1);
    idle(10);
    // R6: long hysteresis
    n = cyc;
    edge_at(0, n + 1, 2, 1, "R3");
    do_write(4'b1111, 1'b1);
    idle(4);
    n = cyc;
    edge_at(0, n + 1, 32, 0, "R6");
    push(n + 33, 0, 0, 1, 5'b01101, "R6");
    do_write(4'b1101, 1'b1);
    idle(34);
    // R8: re-enable mid turn-off
    do_write(4'b1111, 1'b1);
    idle(4);
    n = cyc;
    t0 = n + 1;
    for (int k = 0; k < 40; k++) push(t0 + k, 0, 1, 0, '0, "R8");
    push(t0 + 40, 0, 1, 1, 5'b11111, "R8");
    do_write(4'b1101, 1'b1);
    idle(9);
    do_write(4'b1111, 1'b1);
    idle(32);
    // R7: hardware ownership, enable bit ignored
    n = cyc;
    edge_at(0, n + 1, 2, 0, "R7");
    edge_at(1, n + 1, 2, 0, "R7");
    do_write(4'b0010, 1'b1);
    idle(4);
    n = cyc;
    edge_at(0, n + 1, 2, 1, "R7");
    edge_at(1, n + 1, 2, 1, "R7");
    hw_req = 1'b1;
    idle(4);
    do_write(4'b0110, 1'b1);
    idle(2);
    n = cyc;
    edge_at(0, n + 1, 8, 0, "R7");
    edge_at(1, n + 1, 8, 0, "R7");
    hw_req = 1'b0;
    idle(10);
    // R9: back to software with enable 0
    n = cyc;
    push(n + 4, 0, 0, 1, 5'b00001, "R9");
    edge_at(1, n + 1, 2, 1, "R9");
    do_write(4'b0001, 1'b1);
    idle(6);
    if (sb.size() != 0) begin
      fails += sb.size();
      $display("FAIL R1 unchecked=%0d expected=0", sb.size());
    end
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL R1 watchdog cyc=%0d expected=end", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule